// File: doc/BRIEF.md
# Two-Phase Shift-Register-Latch Scan Chain

This block is a chain of N storage cells, each built as a pair of stages: a first stage (L1) and a second stage (L2). In functional use, every L1 takes its own parallel data bit when the capture strobe is high, and the cell acts like a D flip-flop. In test use, two separate shift strobes move a serial bit stream through the chain. Strobe A loads every L1 from its cell's serial input. Strobe B then copies every L1 into its L2. The serial input of each cell is the L2 of the cell before it, so one A pulse followed by one B pulse advances the whole chain by one position.

All three strobes are enables sampled on the rising edge of one free-running clock. To read out a captured state, issue one B pulse, then N-1 A/B pairs, and watch the serial output. To preset the chain, apply N A/B pairs while presenting one bit per pair on the serial input. Raising two or more strobes together is a protocol violation. The block reports it on a flag in the same cycle and keeps every stage unchanged.

Top module: `lssd_scan_chain`

## Requirements
- R1: When only `cap_en` is high at a rising clock edge, `l1_q[i]` takes `func_d[i]` for every cell i. `l2_q` does not change.
- R2: When only `shift_a` is high at a rising clock edge, every L1 loads its cell's serial input. `l2_q` does not change.
- R3: When only `shift_b` is high at a rising clock edge, `l2_q` takes the value `l1_q` had before that edge. `l1_q` does not change.
- R4: Cell 0's serial input is `scan_in`. Cell i+1's serial input is `l2_q[i]`. `scan_out` always equals `l2_q[N-1]`.
- R5: After a capture, one B pulse puts captured cell N-1 on `scan_out`. Each following A/B pair then shows the next lower cell, so the k-th pair shows cell N-1-k.
- R6: After N A/B pairs, the bit given on `scan_in` during pair k (k counted from 0) sits in both L1 and L2 of cell N-1-k. Functional capture then works again as in R1.
- R7: `strobe_err` is high in any cycle where two or more of `cap_en`, `shift_a` and `shift_b` are high. At that edge neither `l1_q` nor `l2_q` changes.
- R8: While `rst_n` is low, every L1 and L2 is 0. This takes effect at once, without waiting for a clock edge.
- R9: Repeated `shift_a` pulses with no `shift_b` between them reload L1 from the same L2 values. No data moves further along the chain.
- R10: When no strobe is high, `l1_q` and `l2_q` hold their values and `strobe_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| func_d | input | N | Parallel functional data, one bit per cell |
| cap_en | input | 1 | Functional capture strobe into L1 |
| shift_a | input | 1 | Scan strobe A: L1 loads its serial input |
| shift_b | input | 1 | Scan strobe B: L2 loads L1 |
| scan_in | input | 1 | Serial input of cell 0 |
| l1_q | output | N | Parallel view of all L1 stages |
| l2_q | output | N | Parallel view of all L2 stages |
| scan_out | output | 1 | L2 of the last cell |
| strobe_err | output | 1 | More than one strobe is high this cycle |

## Verification
The per-cell assertions assume the strobes are legal: at most one is high in a cycle. Each one states what a single strobe does to a stage. The hold assertion in the top level covers every illegal combination. The bench drives inputs only at falling edges, so each strobe value is stable across exactly one rising edge. Illegal combinations appear only in dedicated cycles, and the model checks them as hold cycles. Reset is asserted and released at falling edges, so the stages never see a release too close to a rising edge.

// File: rtl/lssd_pkg.sv
package lssd_pkg;
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_LOAD_A  = 2'd2,
    OP_XFER_B  = 2'd3
  } lssd_op_e;
endpackage

// File: rtl/lssd_strobe_decode.sv
module lssd_strobe_decode
  import lssd_pkg::*;
(
  input  logic     cap_en,
  input  logic     shift_a,
  input  logic     shift_b,
  output lssd_op_e op,
  output logic     conflict
);
  logic [1:0] active_cnt;

  always_comb begin
    active_cnt = {1'b0, cap_en} + {1'b0, shift_a} + {1'b0, shift_b};
    conflict   = (active_cnt > 2'd1);
    op         = OP_HOLD;
    if (!conflict) begin
      if (cap_en)       op = OP_CAPTURE;
      else if (shift_a) op = OP_LOAD_A;
      else if (shift_b) op = OP_XFER_B;
    end
  end
endmodule

// File: rtl/lssd_cell.sv
module lssd_cell
  import lssd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  lssd_op_e op,
  input  logic     func_bit,
  input  logic     ser_in,
  output logic     l1,
  output logic     l2
);
  logic l1_nxt, l2_nxt;
  logic l1_en, l2_en;

  always_comb begin
    l1_en  = (op == OP_CAPTURE) || (op == OP_LOAD_A);
    l2_en  = (op == OP_XFER_B);
    l1_nxt = (op == OP_CAPTURE) ? func_bit : ser_in;
    l2_nxt = l1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1 <= 1'b0;
    end else if (l1_en) begin
      l1 <= l1_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2 <= 1'b0;
    end else if (l2_en) begin
      l2 <= l2_nxt;
    end
  end

  AST_CAPTURE_LOADS_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CAPTURE) |=> (l1 == $past(func_bit))); // R1
  AST_SHIFT_A_LOADS_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD_A) |=> (l1 == $past(ser_in))); // R2
  AST_SHIFT_B_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XFER_B) |=> (l2 == $past(l1))); // R3
  AST_L2_ONLY_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_XFER_B) |=> $stable(l2)); // R2
  AST_L1_HELD_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XFER_B) |=> $stable(l1)); // R3
endmodule

// File: rtl/lssd_scan_chain.sv
module lssd_scan_chain
  import lssd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] func_d,
  input  logic         cap_en,
  input  logic         shift_a,
  input  logic         shift_b,
  input  logic         scan_in,
  output logic [N-1:0] l1_q,
  output logic [N-1:0] l2_q,
  output logic         scan_out,
  output logic         strobe_err
);
  localparam int LAST = N - 1;

  lssd_op_e     op;
  logic         conflict;
  logic [N-1:0] ser_link;

  lssd_strobe_decode u_decode (
    .cap_en  (cap_en),
    .shift_a (shift_a),
    .shift_b (shift_b),
    .op      (op),
    .conflict(conflict)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_cell
      if (gi == 0) begin : g_head
        assign ser_link[gi] = scan_in;
      end else begin : g_body
        assign ser_link[gi] = l2_q[gi-1];
      end
      lssd_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .func_bit(func_d[gi]),
        .ser_in  (ser_link[gi]),
        .l1      (l1_q[gi]),
        .l2      (l2_q[gi])
      );
    end
  endgenerate

  assign scan_out   = l2_q[LAST];
  assign strobe_err = conflict;

  AST_CONFLICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |=> ($stable(l1_q) && $stable(l2_q))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !shift_a && !shift_b) |=> ($stable(l1_q) && $stable(l2_q))); // R10
  AST_A_ADVANCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_a && !cap_en && !shift_b) |=> (l1_q == {$past(l2_q[N-2:0]), $past(scan_in)})); // R4
endmodule

// File: tb/lssd_scan_chain_bench.sv
`timescale 1ns/1ps
module lssd_scan_chain_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] func_d;
  logic         cap_en, shift_a, shift_b, scan_in;
  logic [N-1:0] l1_q, l2_q;
  logic         scan_out, strobe_err;

  int total = 0;
  int bad   = 0;
  logic [N-1:0] m_l1, m_l2;

  always #2.5 clk = ~clk;

  lssd_scan_chain #(.N(N)) u_lssd_scan_chain (
    .clk(clk), .rst_n(rst_n), .func_d(func_d), .cap_en(cap_en),
    .shift_a(shift_a), .shift_b(shift_b), .scan_in(scan_in),
    .l1_q(l1_q), .l2_q(l2_q), .scan_out(scan_out), .strobe_err(strobe_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " l1"}, 64'(l1_q), 64'(m_l1));
    chk({tag, " l2"}, 64'(l2_q), 64'(m_l2));
    chk({tag, " R4 scan_out"}, 64'(scan_out), 64'(m_l2[N-1]));
  endtask

  task automatic step(input logic c, input logic a, input logic b, input logic si,
                      input logic [N-1:0] d, input string tag);
    int n_act;
    @(negedge clk);
    cap_en = c; shift_a = a; shift_b = b; scan_in = si; func_d = d;
    n_act = int'(c) + int'(a) + int'(b);
    #1 chk({tag, " R7 err"}, 64'(strobe_err), 64'(n_act > 1));
    @(posedge clk);
    if (n_act == 1) begin
      if (c)      m_l1 = d;
      else if (a) m_l1 = {m_l2[N-2:0], si};
      else        m_l2 = m_l1;
    end
    #1 chk_state(tag);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    logic         exp_q[$];
    cap_en = 0; shift_a = 0; shift_b = 0; scan_in = 0; func_d = '0;
    rst_n = 1'b0;
    m_l1 = '0; m_l2 = '0;
    repeat (3) @(posedge clk);
    #1 chk_state("R8 reset");
    @(negedge clk); rst_n = 1'b1;

    // R1 capture, R3 transfer, R5 readout
    pat = 8'hA5;
    step(1, 0, 0, 0, pat, "R1 capture");
    chk("R1 l1 equals func_d", 64'(l1_q), 64'(pat));
    step(0, 0, 1, 0, '0, "R3 B pulse");
    chk("R3 l2 equals captured", 64'(l2_q), 64'(pat));
    for (int i = N - 1; i >= 0; i--) exp_q.push_back(pat[i]);
    chk("R5 first bit", 64'(scan_out), 64'(exp_q.pop_front()));
    for (int k = 1; k < N; k++) begin
      step(0, 1, 0, 0, '0, "R5 A");
      step(0, 0, 1, 0, '0, "R5 B");
      chk("R5 readout bit", 64'(scan_out), 64'(exp_q.pop_front()));
    end

    // R6 serial preset
    pat = 8'h3C;
    for (int k = 0; k < N; k++) begin
      step(0, 1, 0, pat[N-1-k], '0, "R6 A");
      step(0, 0, 1, 0, '0, "R6 B");
    end
    chk("R6 l2 preset", 64'(l2_q), 64'(pat));
    chk("R6 l1 preset", 64'(l1_q), 64'(pat));

    // R9 repeated A without B
    step(0, 1, 0, 1, '0, "R9 A1");
    step(0, 1, 0, 1, '0, "R9 A2");
    step(0, 1, 0, 1, '0, "R9 A3");
    chk("R9 l2 untouched", 64'(l2_q), 64'(pat));
    chk("R9 l1 one step", 64'(l1_q), 64'({pat[N-2:0], 1'b1}));

    // R10 idle
    step(0, 0, 0, 1, 8'hFF, "R10 idle");
    step(0, 0, 0, 0, 8'h00, "R10 idle");
    chk("R10 err low", 64'(strobe_err), 64'(0));

    // R7 conflicts
    step(1, 1, 0, 0, 8'h0F, "R7 cap+A");
    step(0, 1, 1, 1, 8'h0F, "R7 A+B");
    step(1, 0, 1, 0, 8'hF0, "R7 cap+B");
    step(1, 1, 1, 1, 8'hFF, "R7 all");
    chk("R7 l2 held", 64'(l2_q), 64'(pat));

    // R1 after scan use
    step(1, 0, 0, 0, 8'h96, "R1 recapture");
    chk("R1 recapture value", 64'(l1_q), 64'(8'h96));
    step(0, 0, 1, 0, '0, "R3 B again");

    // R8 asynchronous reset mid-run
    @(negedge clk);
    cap_en = 0; shift_a = 0; shift_b = 0;
    #1 rst_n = 1'b0;
    #0.5 chk("R8 async l1", 64'(l1_q), 64'(0));
    chk("R8 async l2", 64'(l2_q), 64'(0));
    m_l1 = '0; m_l2 = '0;
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, '0, "R8 after");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule